// File: doc/BRIEF.md
# Management Routine Sequencer

This block sits between a host-side controller and a serial management bus master. It turns one start pulse into a short stored routine of register operations. The host picks a routine with a select input and raises start for one cycle. The sequencer then reads the routine's entries from a built-in table, one after another. It hands each operation to the bus master and waits for the master's completion strobe before it moves to the next entry. When the entry is a read, it keeps the returned data. When it reaches the terminating entry, it raises a one-cycle finish pulse and goes back to idle.

The table holds four routines. Two of them reach extended registers through the indirect pair: control register 0x0D and address/data register 0x0E. The other two are plain reads. A table entry has one of four kinds: read, write of a stored constant, write of the host's parameter word, or end. The host parameter supplies either the extended target address or the extended write data. The state machine has three states. IDLE waits for start. ISSUE presents the current entry to the master, or finishes the routine if the entry is the end marker. WAIT holds until the master signals done. The named transitions are:
- IDLE→ISSUE on start.
- ISSUE→WAIT on an operation entry.
- ISSUE→IDLE on the end entry.
- WAIT→ISSUE on master done, which also advances the entry index.

Top module: `mdio_routine_seq`

## Requirements
- R1: After reset, `busy`, `op_valid` and `routine_done` are 0 and `rd_result` is 0x0000.
- R2: A one-cycle `start` sampled while idle makes `busy` 1 from the next cycle. The first entry of the selected routine appears on `op_valid` in that same next cycle. `op_valid` is never 1 while `busy` is 0.
- R3: `routine_sel` is captured when start is accepted. Changing it during a run does not alter the operations issued.
- R4: Each entry is presented as a single-cycle `op_valid` pulse. The following entry is not presented until at least one cycle after `op_done` has been seen for the current one.
- R5: A write-parameter entry drives `op_wdata` with the current `param_data`. A write-constant entry drives the stored value. Reads drive `op_write`=0; writes drive `op_write`=1.
- R6: Routine 0 (extended read) issues four operations in order:
  - write reg 0x0D with {2'b00, 9'b0, DEV} (address function);
  - write reg 0x0E with `param_data`;
  - write reg 0x0D with {2'b01, 9'b0, DEV} (data function);
  - read reg 0x0E.

  DEV is the device-number parameter, default 0x1F.
- R7: Routine 1 (extended write) issues four operations in order:
  - write reg 0x0D with the address function word;
  - write reg 0x0E with the target-address parameter (default 0x0031);
  - write reg 0x0D with the data function word;
  - write reg 0x0E with `param_data`.

  Routine 2 reads reg 0x01. Routine 3 reads reg 0x02 and then reg 0x03.
- R8: `rd_result` takes `op_rdata` on the cycle after `op_done` completes a read entry. It holds its value at all other times.
- R9: When the end entry is reached, `routine_done` is 1 for exactly one cycle and `busy` is 0 in the next cycle.
- R10: A `start` pulse that arrives while a routine is running has no effect on the running routine and does not begin another one.
- R11: `op_done` while idle has no effect: `rd_result` is unchanged and no operation is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to run a routine |
| routine_sel | input | 2 | Routine number, captured on start |
| param_data | input | 16 | Host parameter word used by write-parameter entries |
| op_valid | output | 1 | One-cycle request to the bus master |
| op_write | output | 1 | 1 = write, 0 = read |
| op_reg | output | 5 | Register address for the operation |
| op_wdata | output | 16 | Write data for the operation |
| op_done | input | 1 | Master completion strobe |
| op_rdata | input | 16 | Master read data, valid with op_done |
| busy | output | 1 | Routine in progress |
| routine_done | output | 1 | One-cycle pulse at routine end |
| rd_result | output | 16 | Data of the most recent read entry |

## Verification
The bench varies master latency from zero to three cycles. A design that advanced before `op_done`, or that let the strobe skip an entry, would issue operations early or out of order. It changes `routine_sel` and fires `start` mid-run: a design that did not latch the select would switch to another routine partway through, and one that honoured a late start would restart or extend the run. It also injects a stray `op_done` while idle and writes between reads. A design that captured data on any strobe would corrupt `rd_result`. Routine 3 has two consecutive reads, so the result must be the second read's data.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
    localparam int DATA_W = 16;
    localparam int REG_W  = 5;
    localparam int SEL_W  = 2;
    localparam int IDX_W  = 3;

    localparam logic [REG_W-1:0] REG_CTRL = 5'h0D;
    localparam logic [REG_W-1:0] REG_ADDAT = 5'h0E;

    typedef enum logic [1:0] {
        K_READ   = 2'b00,
        K_WCONST = 2'b01,
        K_WPARAM = 2'b10,
        K_END    = 2'b11
    } kind_e;

    typedef struct packed {
        kind_e             kind;
        logic [REG_W-1:0]  regad;
        logic [DATA_W-1:0] data;
    } entry_t;

    typedef enum logic [1:0] {
        S_IDLE  = 2'b00,
        S_ISSUE = 2'b01,
        S_WAIT  = 2'b10
    } state_e;
endpackage

// File: rtl/mrs_rom.sv
module mrs_rom
    import mrs_pkg::*;
#(
    parameter logic [4:0]        DEV         = 5'h1F,
    parameter logic [DATA_W-1:0] EXT_WR_ADDR = 16'h0031
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [IDX_W-1:0] idx,
    output entry_t           entry
);
    localparam logic [DATA_W-1:0] FN_ADDR = {2'b00, 9'b0, DEV};
    localparam logic [DATA_W-1:0] FN_DATA = {2'b01, 9'b0, DEV};
    localparam logic [DATA_W-1:0] ZERO    = '0;

    always_comb begin
        entry = '{kind: K_END, regad: '0, data: ZERO};
        unique case (sel)
            2'd0: begin
                case (idx)
                    3'd0: entry = '{kind: K_WCONST, regad: REG_CTRL,  data: FN_ADDR};
                    3'd1: entry = '{kind: K_WPARAM, regad: REG_ADDAT, data: ZERO};
                    3'd2: entry = '{kind: K_WCONST, regad: REG_CTRL,  data: FN_DATA};
                    3'd3: entry = '{kind: K_READ,   regad: REG_ADDAT, data: ZERO};
                    default: ;
                endcase
            end
            2'd1: begin
                case (idx)
                    3'd0: entry = '{kind: K_WCONST, regad: REG_CTRL,  data: FN_ADDR};
                    3'd1: entry = '{kind: K_WCONST, regad: REG_ADDAT, data: EXT_WR_ADDR};
                    3'd2: entry = '{kind: K_WCONST, regad: REG_CTRL,  data: FN_DATA};
                    3'd3: entry = '{kind: K_WPARAM, regad: REG_ADDAT, data: ZERO};
                    default: ;
                endcase
            end
            2'd2: begin
                if (idx == 3'd0) entry = '{kind: K_READ, regad: 5'h01, data: ZERO};
            end
            2'd3: begin
                case (idx)
                    3'd0: entry = '{kind: K_READ, regad: 5'h02, data: ZERO};
                    3'd1: entry = '{kind: K_READ, regad: 5'h03, data: ZERO};
                    default: ;
                endcase
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mrs_result.sv
module mrs_result
    import mrs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    always_ff @(posedge clk) begin
        if (!rst_n)       dout <= '0;
        else if (capture) dout <= din;
    end
endmodule

// File: rtl/mdio_routine_seq.sv
module mdio_routine_seq
    import mrs_pkg::*;
#(
    parameter logic [4:0]  DEV         = 5'h1F,
    parameter logic [15:0] EXT_WR_ADDR = 16'h0031
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [1:0]  routine_sel,
    input  logic [15:0] param_data,
    output logic        op_valid,
    output logic        op_write,
    output logic [4:0]  op_reg,
    output logic [15:0] op_wdata,
    input  logic        op_done,
    input  logic [15:0] op_rdata,
    output logic        busy,
    output logic        routine_done,
    output logic [15:0] rd_result
);
    state_e           state_q;
    logic [SEL_W-1:0] sel_q;
    logic [IDX_W-1:0] idx_q;
    entry_t           cur;
    logic             capture;
    logic             at_end;

    mrs_rom #(.DEV(DEV), .EXT_WR_ADDR(EXT_WR_ADDR)) u_rom (
        .sel   (sel_q),
        .idx   (idx_q),
        .entry (cur)
    );

    assign at_end = (cur.kind == K_END);

    // State register and entry pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            sel_q   <= '0;
            idx_q   <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (start) begin
                    sel_q   <= routine_sel;
                    idx_q   <= '0;
                    state_q <= S_ISSUE;
                end
                S_ISSUE: state_q <= at_end ? S_IDLE : S_WAIT;
                S_WAIT: if (op_done) begin
                    idx_q   <= idx_q + 1'b1;
                    state_q <= S_ISSUE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        op_valid     = 1'b0;
        op_write     = 1'b0;
        op_reg       = cur.regad;
        op_wdata     = '0;
        busy         = (state_q != S_IDLE);
        routine_done = 1'b0;
        capture      = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_ISSUE: begin
                op_valid     = !at_end;
                routine_done = at_end;
                op_write     = (cur.kind == K_WCONST) || (cur.kind == K_WPARAM);
                op_wdata     = (cur.kind == K_WPARAM) ? param_data :
                               (cur.kind == K_WCONST) ? cur.data : '0;
            end
            S_WAIT: capture = op_done && (cur.kind == K_READ);
            default: ;
        endcase
    end

    mrs_result u_res (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .din     (op_rdata),
        .dout    (rd_result)
    );
endmodule

// File: rtl/mrs_checker.sv
module mrs_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        op_valid,
    input logic        op_done,
    input logic        busy,
    input logic        routine_done,
    input logic [15:0] rd_result
);
    p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> !op_valid);
    p_no_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !op_valid);
    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    p_done_to_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        routine_done |=> !busy);
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        routine_done |=> !routine_done);
    p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !op_done |=> $stable(rd_result));
    p_run_continues_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !routine_done) |=> busy);
endmodule

bind mdio_routine_seq mrs_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .op_valid     (op_valid),
    .op_done      (op_done),
    .busy         (busy),
    .routine_done (routine_done),
    .rd_result    (rd_result)
);

// File: tb/sim_mdio_routine_seq.sv
`timescale 1ns/1ps
module sim_mdio_routine_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  routine_sel = 2'd0;
    logic [15:0] param_data = 16'h0000;
    logic        op_valid, op_write, busy, routine_done;
    logic [4:0]  op_reg;
    logic [15:0] op_wdata, rd_result;
    logic        op_done = 1'b0;
    logic [15:0] op_rdata = 16'h0000;

    always #4 clk = ~clk;   // 125 MHz

    mdio_routine_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .routine_sel(routine_sel),
        .param_data(param_data), .op_valid(op_valid), .op_write(op_write),
        .op_reg(op_reg), .op_wdata(op_wdata), .op_done(op_done),
        .op_rdata(op_rdata), .busy(busy), .routine_done(routine_done),
        .rd_result(rd_result)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    string ctx = "";

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s%s %s: actual=%h expected=%h", ctx, tag, what, act, exp);
        end
    endtask

    // Bus master model
    int  lat = 0;
    int  inj_req = 0;
    int  inj_seen = 0;
    bit  pend = 0;
    int  cnt = 0;
    logic [15:0] next_rd = 16'h1357;
    always @(negedge clk) begin
        op_done = 1'b0;
        if (inj_req != inj_seen) begin
            inj_seen = inj_req;
            op_done  = 1'b1;
            op_rdata = 16'hDEAD;
        end else if (pend) begin
            if (cnt == 0) begin
                op_done  = 1'b1;
                op_rdata = next_rd;
                next_rd  = next_rd + 16'h1111;
                pend     = 0;
            end else cnt--;
        end else if (op_valid) begin
            pend = 1;
            cnt  = lat;
        end
    end

    // Reference model: expected operation queue built from the requirements
    int q_kind[$];   // 0 read, 1 write constant, 2 write parameter
    int q_reg[$];
    int q_data[$];
    int mph = 0;     // 0 idle, 1 issue, 2 wait
    logic [15:0] m_res = 16'h0000;

    task automatic push_op(input int k, input int r, input int d);
        q_kind.push_back(k); q_reg.push_back(r); q_data.push_back(d);
    endtask

    task automatic load_routine(input int sel);
        q_kind.delete(); q_reg.delete(); q_data.delete();
        case (sel)
            0: begin  // R6
                push_op(1, 13, 16'h001F); push_op(2, 14, 0);
                push_op(1, 13, 16'h401F); push_op(0, 14, 0);
            end
            1: begin  // R7
                push_op(1, 13, 16'h001F); push_op(1, 14, 16'h0031);
                push_op(1, 13, 16'h401F); push_op(2, 14, 0);
            end
            2: push_op(0, 1, 0);
            default: begin push_op(0, 2, 0); push_op(0, 3, 0); end
        endcase
    endtask

    bit model_on = 0;
    always @(negedge clk) begin
        #3;
        cycles++;
        if (model_on) begin
            bit ev, ed, eb;
            ev = (mph == 1) && (q_kind.size() > 0);
            ed = (mph == 1) && (q_kind.size() == 0);
            eb = (mph != 0);
            chk(busy == eb, "R2", "busy", busy, eb);
            chk(op_valid == ev, "R4", "op_valid", op_valid, ev);
            chk(routine_done == ed, "R9", "routine_done", routine_done, ed);
            chk(rd_result == m_res, "R8", "rd_result", rd_result, m_res);
            if (ev) begin
                int ew;
                ew = (q_kind[0] == 2) ? int'(param_data) : (q_kind[0] == 1 ? q_data[0] : 0);
                chk(op_write == (q_kind[0] != 0), "R5", "op_write", op_write, q_kind[0] != 0);
                chk(op_reg == q_reg[0], "R6/R7", "op_reg", op_reg, q_reg[0]);
                if (q_kind[0] != 0)
                    chk(op_wdata == ew, "R5", "op_wdata", op_wdata, ew);
            end
            case (mph)
                0: if (start) begin load_routine(routine_sel); mph = 1; end
                1: mph = (q_kind.size() == 0) ? 0 : 2;
                default: if (op_done) begin
                    if (q_kind[0] == 0) m_res = op_rdata;
                    void'(q_kind.pop_front()); void'(q_reg.pop_front());
                    void'(q_data.pop_front());
                    mph = 1;
                end
            endcase
        end
    end

    task automatic pulse_start(input logic [1:0] sel);
        @(negedge clk);
        routine_sel = sel;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (2) @(negedge clk);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        ctx = "R1/";
        chk(busy == 0, "R1", "busy", busy, 0);
        chk(op_valid == 0, "R1", "op_valid", op_valid, 0);
        chk(routine_done == 0, "R1", "routine_done", routine_done, 0);
        chk(rd_result == 0, "R1", "rd_result", rd_result, 0);
        rst_n = 1'b1;
        @(negedge clk);
        model_on = 1;

        ctx = "ext-read/";
        lat = 0; param_data = 16'h0123;
        pulse_start(2'd0);
        wait_idle();

        ctx = "R3/R10/";
        lat = 2; param_data = 16'hBEEF;
        pulse_start(2'd1);
        routine_sel = 2'd3;           // R3: late select change
        repeat (3) @(negedge clk);
        start = 1'b1;                 // R10: start while running
        @(negedge clk);
        start = 1'b0;
        wait_idle();
        chk(busy == 0, "R10", "busy after ignored start", busy, 0);

        ctx = "plain-read/";
        lat = 1;
        pulse_start(2'd2);
        wait_idle();

        ctx = "R11/";
        inj_req++;                    // stray op_done while idle
        repeat (3) @(negedge clk);
        chk(op_valid == 0, "R11", "op_valid after stray done", op_valid, 0);

        ctx = "two-reads/";
        lat = 3;
        pulse_start(2'd3);
        wait_idle();

        ctx = "back-to-back/";
        lat = 0; param_data = 16'h00A5;
        pulse_start(2'd0);
        wait_idle();

        model_on = 0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule